// File: doc/BRIEF.md
# Token-Ring Shared-Memory Node

This block sits between one CPU and a one-way synchronous ring that carries shared-memory blocks between nodes. It keeps a table entry for every shared block. Each entry holds four flags: present, sole-copy, homed-here and lost-copy notice. It also holds the cache slot where the block's word is stored. A node owns a fixed set of home blocks: those whose low index bits equal its node number. Each home block has a reserved slot. A small pool of extra slots holds copies of blocks homed elsewhere.

A CPU access that the table can serve completes locally and puts nothing on the ring. Any other access waits for the circulating token and then launches one of three packets: a read request, an invalidation, or a combined read-and-invalidate. The node keeps the token while its packet travels once round the ring. The packet's return is the completion event. When the node takes the packet back, it installs or updates the block and answers the CPU. When a block arrives and the pool is full, the node first sends a pseudo-randomly chosen non-home copy back to its home node, and releases the token only after that packet returns too. Packets from other nodes pass through with one register stage. The node fills or drops its own copies on the way.

The CPU request side uses valid/ready. A request must stay steady while valid is high and not ready, and it is taken on a clock edge where both are high. The response is a one-cycle pulse with no back-pressure. A ring word is present when `ring_in_vld` is high. The ring never stalls, so every word must be taken in the cycle it arrives.

Top module: `rn_node`

## Requirements
- R1: After reset every home block is present and sole-copy, and its slot holds the block index as data. No other block is present. `ring_out_vld`, `cpu_rsp_valid` and `node_irq` are low, and `cpu_req_ready` is high.
- R2: A read of a present block answers one cycle after acceptance with its data. The node puts no packet on the ring for it.
- R3: A write to a present sole-copy block stores the word and answers one cycle after acceptance, echoing the word. The node puts no packet on the ring for it.
- R4: A read of an absent block waits for the token (`ring_in_vld`=1, `ring_in_tok`=1). One cycle after the token arrives, the node puts out a packet with kind 0 (read), its own node number as source, the block, fill=0 and data 0. When that packet returns with fill=1, the node stores the data, answers the CPU with it and puts the token out in the same cycle.
- R5: A word from another source or a token the node does not need appears on `ring_out` one cycle later. A kind-0 packet with fill=0 for a block the node holds leaves with fill=1 and the node's data, and the node's copy stops being sole-copy. A packet already filled passes with its data unchanged.
- R6: A write to a present block that is not sole-copy sends a kind-1 (invalidate) packet on the token. When that packet returns, the node stores the word, marks the block sole-copy, answers and puts the token out.
- R7: A write to an absent block sends kind 2 (read-and-invalidate). On return the node installs the written word as a sole copy. A passing kind-2 packet for a block the node holds takes the node's data only if fill=0 and sets fill. In either case the node drops its copy.
- R8: A passing kind-1 packet makes the node drop its copy of that block.
- R9: Installing a non-home block with no free pool slot evicts a pool block chosen by an LFSR; home blocks are never chosen. The node sends kind 3 (evict) with fill=1 and the victim's block and data in place of the token, and puts the token out one cycle after that packet returns.
- R10: A passing kind-3 packet for a block homed at this node stores its data there, and the block becomes present and not sole-copy.
- R11: `node_irq` is high while any block has had its copy removed by a passing packet and has not been installed again.
- R12: `cpu_req_ready` is low while a request is outstanding and in any cycle where a packet from another node is on `ring_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_ready | output | 1 | Node can take a request |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_blk | input | BW | Shared block index |
| cpu_req_wdata | input | DW | Write word |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | DW | Read data, or the written word |
| ring_in_vld | input | 1 | Ring word present |
| ring_in_tok | input | 1 | Word is the token |
| ring_in_kind | input | 2 | 0 read, 1 invalidate, 2 read-and-invalidate, 3 evict |
| ring_in_src | input | IW | Sending node |
| ring_in_blk | input | BW | Block index |
| ring_in_fill | input | 1 | Data field already supplied |
| ring_in_data | input | DW | Block data |
| ring_out_vld | output | 1 | Ring word present |
| ring_out_tok | output | 1 | Word is the token |
| ring_out_kind | output | 2 | Packet kind |
| ring_out_src | output | IW | Sending node |
| ring_out_blk | output | BW | Block index |
| ring_out_fill | output | 1 | Data field supplied |
| ring_out_data | output | DW | Block data |
| node_irq | output | 1 | Lost-copy notice pending |

## Verification
The hardest case to reach is eviction. It happens only when a packet for a non-home block returns while every pool slot is occupied. The victim depends on the LFSR phase. The bench plays the rest of the ring itself: it hands out the token and returns each packet with data. It makes enough misses in a row to fill the pool, then one more. Since the victim cannot be predicted, the bench accepts either pool block. It checks that the evicted data matches its own record of that block, and that the token appears only after the evict packet has come back.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic [1:0] {PK_READ = 2'd0, PK_INV = 2'd1, PK_RDINV = 2'd2, PK_EVICT = 2'd3} pkind_e;
  typedef enum logic [1:0] {S_IDLE, S_WTOK, S_WRET, S_WEVR} nstate_e;
  typedef enum logic [2:0] {T_NONE, T_WRITE, T_SHARE, T_DROP, T_INSTALL, T_HOMEFILL} tblop_e;
endpackage

// File: rtl/rn_lfsr.sv
module rn_lfsr #(
  parameter int W = 8,
  parameter logic [W-1:0] TAPS = 'hB8,
  parameter logic [W-1:0] SEED = 'h1,
  parameter int OUTW = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [OUTW-1:0] rnd
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= SEED;
    else        q <= {q[W-2:0], ^(q & TAPS)};
  end

  assign rnd = q[OUTW-1:0];

  a_r9_lfsr_alive: assert property (@(posedge clk) disable iff (!rst_n) q != '0);
endmodule

// File: rtl/rn_table.sv
module rn_table
  import rn_pkg::*;
#(
  parameter int NODE_ID = 1,
  parameter int NNODE   = 4,
  parameter int NBLK    = 8,
  parameter int NREM    = 2,
  parameter int DW      = 16,
  parameter int RW      = 1,
  localparam int IW     = $clog2(NNODE),
  localparam int BW     = $clog2(NBLK),
  localparam int NHOME  = NBLK / NNODE,
  localparam int NSLOT  = NHOME + NREM,
  localparam int SW     = $clog2(NSLOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] a_blk,
  output logic          a_v,
  output logic          a_e,
  output logic [DW-1:0] a_data,
  input  logic [BW-1:0] b_blk,
  output logic          b_v,
  output logic          b_h,
  output logic [DW-1:0] b_data,
  input  tblop_e        op,
  input  logic [BW-1:0] op_blk,
  input  logic [DW-1:0] op_data,
  input  logic          op_excl,
  input  logic [RW-1:0] rnd,
  output logic          need_evict,
  output logic [BW-1:0] victim_blk,
  output logic [DW-1:0] victim_data,
  output logic          irq
);
  logic          tv [NBLK];
  logic          te [NBLK];
  logic          th [NBLK];
  logic          ti [NBLK];
  logic [SW-1:0] tloc [NBLK];
  logic [DW-1:0] sdata [NSLOT];
  logic [BW-1:0] sblk [NSLOT];
  logic          sused [NSLOT];

  logic          free_found;
  logic [SW-1:0] free_idx, vic, ins_slot;
  logic          ins_evict;

  function automatic logic is_home(input int b);
    return (b % NNODE) == NODE_ID;
  endfunction

  assign a_v    = tv[a_blk];
  assign a_e    = te[a_blk];
  assign a_data = sdata[tloc[a_blk]];
  assign b_v    = tv[b_blk];
  assign b_h    = th[b_blk];
  assign b_data = sdata[tloc[b_blk]];

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int s = NSLOT - 1; s >= NHOME; s--) begin
      if (!sused[s]) begin
        free_found = 1'b1;
        free_idx   = SW'(s);
      end
    end
  end

  generate
    if (NREM == 1) begin : g_vic_single
      assign vic = SW'(NHOME);
    end else begin : g_vic_lfsr
      assign vic = SW'(NHOME) + SW'(rnd);
    end
  endgenerate

  assign victim_blk  = sblk[vic];
  assign victim_data = sdata[vic];
  assign need_evict  = !th[b_blk] && !free_found;
  assign ins_evict   = !th[op_blk] && !free_found;
  assign ins_slot    = th[op_blk] ? SW'(op_blk >> IW) : (free_found ? free_idx : vic);

  always_comb begin
    irq = 1'b0;
    for (int b = 0; b < NBLK; b++) irq = irq | ti[b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBLK; b++) begin
        tv[b]   <= is_home(b);
        te[b]   <= is_home(b);
        th[b]   <= is_home(b);
        ti[b]   <= 1'b0;
        tloc[b] <= is_home(b) ? SW'(b / NNODE) : '0;
      end
      for (int s = 0; s < NSLOT; s++) begin
        sused[s] <= (s < NHOME);
        sblk[s]  <= (s < NHOME) ? BW'(s * NNODE + NODE_ID) : '0;
        sdata[s] <= (s < NHOME) ? DW'(s * NNODE + NODE_ID) : '0;
      end
    end else begin
      case (op)
        T_WRITE: begin
          sdata[tloc[op_blk]] <= op_data;
          if (op_excl) te[op_blk] <= 1'b1;
        end
        T_SHARE: te[op_blk] <= 1'b0;
        T_DROP: begin
          tv[op_blk] <= 1'b0;
          te[op_blk] <= 1'b0;
          ti[op_blk] <= 1'b1;
          if (!th[op_blk]) sused[tloc[op_blk]] <= 1'b0;
        end
        T_INSTALL: begin
          if (ins_evict) begin
            tv[sblk[vic]] <= 1'b0;
            te[sblk[vic]] <= 1'b0;
          end
          tv[op_blk]      <= 1'b1;
          te[op_blk]      <= op_excl;
          ti[op_blk]      <= 1'b0;
          tloc[op_blk]    <= ins_slot;
          sdata[ins_slot] <= op_data;
          sblk[ins_slot]  <= op_blk;
          sused[ins_slot] <= 1'b1;
        end
        T_HOMEFILL: begin
          tv[op_blk] <= 1'b1;
          te[op_blk] <= 1'b0;
          ti[op_blk] <= 1'b0;
          sdata[SW'(op_blk >> IW)] <= op_data;
        end
        default: ;
      endcase
    end
  end

  generate
    for (genvar g = 0; g < NBLK; g++) begin : g_chk
      a_r1_excl_needs_valid: assert property (@(posedge clk) disable iff (!rst_n) te[g] |-> tv[g]);
    end
  endgenerate
endmodule

// File: rtl/rn_node.sv
module rn_node
  import rn_pkg::*;
#(
  parameter int NODE_ID = 1,
  parameter int NNODE   = 4,
  parameter int NBLK    = 8,
  parameter int NREM    = 2,
  parameter int DW      = 16,
  localparam int IW     = $clog2(NNODE),
  localparam int BW     = $clog2(NBLK),
  localparam int RW     = (NREM > 1) ? $clog2(NREM) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req_valid,
  output logic          cpu_req_ready,
  input  logic          cpu_req_we,
  input  logic [BW-1:0] cpu_req_blk,
  input  logic [DW-1:0] cpu_req_wdata,
  output logic          cpu_rsp_valid,
  output logic [DW-1:0] cpu_rsp_rdata,
  input  logic          ring_in_vld,
  input  logic          ring_in_tok,
  input  logic [1:0]    ring_in_kind,
  input  logic [IW-1:0] ring_in_src,
  input  logic [BW-1:0] ring_in_blk,
  input  logic          ring_in_fill,
  input  logic [DW-1:0] ring_in_data,
  output logic          ring_out_vld,
  output logic          ring_out_tok,
  output logic [1:0]    ring_out_kind,
  output logic [IW-1:0] ring_out_src,
  output logic [BW-1:0] ring_out_blk,
  output logic          ring_out_fill,
  output logic [DW-1:0] ring_out_data,
  output logic          node_irq
);
  localparam logic [IW-1:0] MY_ID = IW'(NODE_ID);

  nstate_e       state, n_state;
  logic          r_we;
  logic [BW-1:0] r_blk;
  logic [DW-1:0] r_wdata;
  logic          ld;

  logic          a_v, a_e, b_v, b_h, need_evict;
  logic [DW-1:0] a_data, b_data, victim_data;
  logic [BW-1:0] a_blk, victim_blk;
  logic [RW-1:0] rnd;

  tblop_e        t_op;
  logic [BW-1:0] t_blk;
  logic [DW-1:0] t_data;
  logic          t_excl;

  logic          n_vld, n_tok, n_fill, n_rsp;
  logic [1:0]    n_kind;
  logic [IW-1:0] n_src;
  logic [BW-1:0] n_blk;
  logic [DW-1:0] n_data, n_rdata;

  logic fp, own, tok_in, accept;
  assign tok_in = ring_in_vld && ring_in_tok;
  assign fp     = ring_in_vld && !ring_in_tok && (ring_in_src != MY_ID);
  assign own    = ring_in_vld && !ring_in_tok && (ring_in_src == MY_ID);
  assign cpu_req_ready = (state == S_IDLE) && !fp;
  assign accept = cpu_req_valid && cpu_req_ready;
  assign a_blk  = (state == S_IDLE) ? cpu_req_blk : r_blk;

  rn_lfsr #(.W(8), .OUTW(RW)) u_lfsr (.clk(clk), .rst_n(rst_n), .rnd(rnd));

  rn_table #(.NODE_ID(NODE_ID), .NNODE(NNODE), .NBLK(NBLK), .NREM(NREM), .DW(DW), .RW(RW)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .a_blk(a_blk), .a_v(a_v), .a_e(a_e), .a_data(a_data),
    .b_blk(ring_in_blk), .b_v(b_v), .b_h(b_h), .b_data(b_data),
    .op(t_op), .op_blk(t_blk), .op_data(t_data), .op_excl(t_excl), .rnd(rnd),
    .need_evict(need_evict), .victim_blk(victim_blk), .victim_data(victim_data), .irq(node_irq)
  );

  always_comb begin
    t_op = T_NONE; t_blk = ring_in_blk; t_data = ring_in_data; t_excl = 1'b0;
    n_vld = ring_in_vld; n_tok = ring_in_tok; n_kind = ring_in_kind; n_src = ring_in_src;
    n_blk = ring_in_blk; n_fill = ring_in_fill; n_data = ring_in_data;
    n_rsp = 1'b0; n_rdata = cpu_rsp_rdata; n_state = state; ld = 1'b0;

    if (fp && b_v) begin
      case (pkind_e'(ring_in_kind))
        PK_READ:  if (!ring_in_fill) begin n_fill = 1'b1; n_data = b_data; t_op = T_SHARE; end
        PK_INV:   t_op = T_DROP;
        PK_RDINV: begin
          if (!ring_in_fill) begin n_fill = 1'b1; n_data = b_data; end
          t_op = T_DROP;
        end
        default: ;
      endcase
    end
    if (fp && b_h && (ring_in_kind == PK_EVICT)) t_op = T_HOMEFILL;

    if (own) begin
      n_vld = 1'b1; n_tok = 1'b1; n_kind = '0; n_src = '0; n_blk = '0; n_fill = 1'b0; n_data = '0;
      n_state = S_IDLE;
      if (state == S_WRET) begin
        n_rsp = 1'b1;
        if (ring_in_kind == PK_INV) begin
          t_op = T_WRITE; t_blk = r_blk; t_data = r_wdata; t_excl = 1'b1;
          n_rdata = r_wdata;
        end else begin
          t_op = T_INSTALL; t_data = r_we ? r_wdata : ring_in_data; t_excl = r_we;
          n_rdata = t_data;
          if (need_evict) begin
            n_tok = 1'b0; n_kind = PK_EVICT; n_src = MY_ID; n_blk = victim_blk;
            n_fill = 1'b1; n_data = victim_data; n_state = S_WEVR;
          end
        end
      end
    end

    if (tok_in && (state == S_WTOK)) begin
      n_tok = 1'b0; n_src = MY_ID; n_blk = r_blk; n_fill = 1'b0; n_data = '0;
      n_kind = !r_we ? PK_READ : (a_v ? PK_INV : PK_RDINV);
      n_state = S_WRET;
    end

    if (accept) begin
      if (!cpu_req_we && a_v) begin
        n_rsp = 1'b1; n_rdata = a_data;
      end else if (cpu_req_we && a_v && a_e) begin
        t_op = T_WRITE; t_blk = cpu_req_blk; t_data = cpu_req_wdata; t_excl = 1'b1;
        n_rsp = 1'b1; n_rdata = cpu_req_wdata;
      end else begin
        ld = 1'b1; n_state = S_WTOK;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; r_we <= 1'b0; r_blk <= '0; r_wdata <= '0;
      ring_out_vld <= 1'b0; ring_out_tok <= 1'b0; ring_out_kind <= '0; ring_out_src <= '0;
      ring_out_blk <= '0; ring_out_fill <= 1'b0; ring_out_data <= '0;
      cpu_rsp_valid <= 1'b0; cpu_rsp_rdata <= '0;
    end else begin
      state <= n_state;
      if (ld) begin r_we <= cpu_req_we; r_blk <= cpu_req_blk; r_wdata <= cpu_req_wdata; end
      ring_out_vld <= n_vld; ring_out_tok <= n_tok; ring_out_kind <= n_kind; ring_out_src <= n_src;
      ring_out_blk <= n_blk; ring_out_fill <= n_fill; ring_out_data <= n_data;
      cpu_rsp_valid <= n_rsp; cpu_rsp_rdata <= n_rdata;
    end
  end

  a_r5_pass_latency: assert property (@(posedge clk) disable iff (!rst_n)
    fp |=> (ring_out_vld && !ring_out_tok && ring_out_src == $past(ring_in_src) && ring_out_blk == $past(ring_in_blk)));
  a_r4_token_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WRET || state == S_WEVR) |-> !(ring_out_vld && ring_out_tok));
  a_r2_hit_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cpu_req_we && a_v) |=> cpu_rsp_valid);
  a_r9_evict_not_home: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_out_vld && !ring_out_tok && ring_out_kind == PK_EVICT && ring_out_src == MY_ID) |-> (ring_out_blk[IW-1:0] != MY_ID));
endmodule

// File: tb/rn_node_tb_top.sv
module rn_node_tb_top;
  localparam int ID = 1;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cv = 1'b0, cwe = 1'b0, crdy, rv, rt = 1'b0, rf = 1'b0, ri = 1'b0;
  logic [2:0] cblk = '0, rblk = '0;
  logic [15:0] cwd = '0, rdat = '0;
  logic [1:0] rk = '0, rs = '0;
  logic rsp_v, ov, ot, of_, irq;
  logic [15:0] rsp_d, od;
  logic [1:0] ok_, os;
  logic [2:0] ob;
  int nchk = 0, nerr = 0;
  logic [15:0] mdl [8];
  int nevict = 0;

  always #5 clk = ~clk;

  rn_node #(.NODE_ID(ID)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req_valid(cv), .cpu_req_ready(crdy), .cpu_req_we(cwe),
    .cpu_req_blk(cblk), .cpu_req_wdata(cwd), .cpu_rsp_valid(rsp_v), .cpu_rsp_rdata(rsp_d),
    .ring_in_vld(ri), .ring_in_tok(rt), .ring_in_kind(rk), .ring_in_src(rs), .ring_in_blk(rblk),
    .ring_in_fill(rf), .ring_in_data(rdat), .ring_out_vld(ov), .ring_out_tok(ot), .ring_out_kind(ok_),
    .ring_out_src(os), .ring_out_blk(ob), .ring_out_fill(of_), .ring_out_data(od), .node_irq(irq));

  assign rv = ri;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin nerr++; $display("FAIL %s: actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic chk_pkt(input string req, input int v, input int t, input int k, input int s,
                         input int b, input int f, input int d);
    chk(req, {ov, ot, ok_, os, ob, of_, od}, {v[0], t[0], k[1:0], s[1:0], b[2:0], f[0], d[15:0]});
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic step_cpu(input bit we, input int b, input int wd);
    cv = 1'b1; cwe = we; cblk = b[2:0]; cwd = wd[15:0];
    tick();
    cv = 1'b0;
  endtask

  task automatic step_ring(input bit t, input int k, input int s, input int b, input int f, input int d);
    ri = 1'b1; rt = t; rk = k[1:0]; rs = s[1:0]; rblk = b[2:0]; rf = f[0]; rdat = d[15:0];
    tick();
    ri = 1'b0; rt = 1'b0;
  endtask

  task automatic local_op(input bit we, input int b, input int wd, input int exp, input string req);
    step_cpu(we, b, wd);
    chk({req, " rsp"}, rsp_v, 1);
    chk({req, " data"}, rsp_d, exp);
    chk({req, " no ring"}, ov, 0);
    if (we) mdl[b] = wd[15:0];
  endtask

  task automatic remote_op(input bit we, input int b, input int wd, input int k, input int fd, input string req);
    int exp, vic;
    step_cpu(we, b, wd);
    chk({req, " waits"}, rsp_v, 0);
    step_ring(1, 0, 0, 0, 0, 0);
    chk_pkt({req, " request pkt"}, 1, 0, k, ID, b, 0, 0);
    step_ring(0, k, ID, b, (k != 1), (k != 1) ? fd : 0);
    exp = we ? wd : fd;
    chk({req, " rsp"}, rsp_v, 1);
    chk({req, " rsp data"}, rsp_d, exp);
    mdl[b] = exp[15:0];
    if (ov && !ot) begin
      nevict++;
      vic = ob;
      chk("R9 victim not home", int'(vic % 4 != ID), 1);
      chk("R9 evict kind/fill", {ok_, of_}, {2'd3, 1'b1});
      chk("R9 evict data", od, mdl[vic]);
      step_ring(0, 3, ID, vic, 1, od);
      chk_pkt("R9 token after evict", 1, 1, 0, 0, 0, 0, 0);
    end else begin
      chk_pkt({req, " token release"}, 1, 1, 0, 0, 0, 0, 0);
    end
  endtask

  // {we, blk[2:0], wdata[15:0], expected rsp[15:0]} on home blocks 1 and 5
  localparam logic [35:0] VEC [7] = '{
    {1'b0, 3'd1, 16'h0000, 16'h0001},
    {1'b0, 3'd5, 16'h0000, 16'h0005},
    {1'b1, 3'd1, 16'hA1A1, 16'hA1A1},
    {1'b0, 3'd1, 16'h0000, 16'hA1A1},
    {1'b1, 3'd5, 16'h0B05, 16'h0B05},
    {1'b0, 3'd5, 16'h0000, 16'h0B05},
    {1'b0, 3'd1, 16'h0000, 16'hA1A1}
  };

  initial begin
    repeat (5000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = 16'(i);
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 ring idle", ov, 0);
    chk("R1 no rsp", rsp_v, 0);
    chk("R1 irq low", irq, 0);
    chk("R1 ready", crdy, 1);

    // R2 / R3 local hits from the vector table
    for (int i = 0; i < 7; i++) begin
      local_op(VEC[i][35], int'(VEC[i][34:32]), int'(VEC[i][31:16]), int'(VEC[i][15:0]),
               VEC[i][35] ? "R3 local write" : "R2 local read");
    end

    // R5 unneeded token forwarded
    step_ring(1, 0, 0, 0, 0, 0);
    chk_pkt("R5 token forwarded", 1, 1, 0, 0, 0, 0, 0);

    // R4 read miss, then R2 hit on the installed copy
    remote_op(0, 2, 0, 0, 'h2222, "R4 read miss");
    local_op(0, 2, 0, 'h2222, "R2 read after fill");

    // R5 first holder fills, later filled packet untouched
    step_ring(0, 0, 2, 5, 0, 0);
    chk_pkt("R5 fill by holder", 1, 0, 0, 2, 5, 1, 'h0B05);
    step_ring(0, 0, 2, 1, 1, 'h7777);
    chk_pkt("R5 filled passes", 1, 0, 0, 2, 1, 1, 'h7777);

    // R6 write to shared block, then sole-copy write is local (R3)
    remote_op(1, 5, 'h5555, 1, 0, "R6 write shared");
    local_op(1, 5, 'h5656, 'h5656, "R3 write after invalidate");

    // R8 foreign invalidate drops copy, R11 irq
    step_ring(0, 1, 3, 2, 0, 0);
    chk_pkt("R8 invalidate forwarded", 1, 0, 1, 3, 2, 0, 0);
    chk("R11 irq set", irq, 1);
    remote_op(0, 2, 0, 0, 'h2323, "R8 read after drop");
    chk("R11 irq cleared", irq, 0);

    // R12 back-pressure under a passing packet
    ri = 1'b1; rt = 1'b0; rk = 2'd0; rs = 2'd2; rblk = 3'd6; rf = 1'b0; rdat = '0;
    cv = 1'b1; cwe = 1'b0; cblk = 3'd1;
    #1 chk("R12 ready low", crdy, 0);
    tick();
    ri = 1'b0; cv = 1'b0;
    chk("R12 no rsp", rsp_v, 0);
    chk_pkt("R12 packet passes", 1, 0, 0, 2, 6, 0, 0);
    step_cpu(0, 1, 0);
    chk("R12 later accepted", rsp_v, 1);

    // R9 eviction when pool full
    remote_op(0, 3, 0, 0, 'h3333, "R4 read miss 3");
    remote_op(0, 4, 0, 0, 'h4444, "R9 read miss 4");
    chk("R9 eviction happened", nevict, 1);
    local_op(0, 1, 0, mdl[1], "R9 home 1 kept");
    local_op(0, 5, 0, mdl[5], "R9 home 5 kept");

    // R7 write miss and exclusive result
    remote_op(1, 6, 'h6666, 2, 'h6006, "R7 write miss");
    local_op(1, 6, 'h6767, 'h6767, "R7 sole copy");

    // R7 passing read-and-invalidate
    step_ring(0, 2, 2, 1, 0, 0);
    chk_pkt("R7 first holder supplies", 1, 0, 2, 2, 1, 1, mdl[1]);
    step_ring(0, 2, 2, 5, 1, 'h9999);
    chk_pkt("R7 later holder passes", 1, 0, 2, 2, 5, 1, 'h9999);
    chk("R7 irq after drop", irq, 1);

    // R10 evict returning home
    step_ring(0, 3, 2, 1, 1, 'h1BAD);
    chk_pkt("R10 evict forwarded", 1, 0, 3, 2, 1, 1, 'h1BAD);
    local_op(0, 1, 0, 'h1BAD, "R10 home refilled");
    remote_op(0, 5, 0, 0, 'h5A5A, "R7 home 5 dropped");
    chk("R11 irq clear", irq, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule